// File: doc/BRIEF.md
# Network Controller Interrupt Status Unit

This unit gathers the interrupt causes of an Ethernet MAC controller into one status word, lets software clear the sticky causes through a write-one-to-acknowledge register, and gates the word with a mask register to raise a single interrupt request. Some status bits are not stored at all. They track the empty flags of the transmit-completion and receive packet-number FIFOs, and the allocator's failed flag. The other bits are sticky and hold an event until it is acknowledged.

Acknowledging the transmit-completion bit also consumes one completed packet number. The unit emits a one-cycle pop strobe to the transmit-completion FIFO so that the next packet number moves to the head. The unit also keeps a port overrun flag for the port status word. A receive overrun sets this flag and the next received packet clears it.

Top module: `nic_irq_status`

## Requirements
- R1: Status bit 0 (transmit done) equals the inverse of `tx_cmp_empty_i` at all times.
- R2: Status bit 1 (receive pending) equals the inverse of `rx_pkt_empty_i` at all times.
- R3: Status bit 3 (allocation done) equals the inverse of `alloc_failed_i` at all times.
- R4: Status bit 4 (receive overrun) sets one cycle after `rx_ovr_evt_i` is high. It stays set, even when packets arrive, until a write to the acknowledge register has bit 4 at 1.
- R5: Status bit 2 (transmit FIFO empty) sets on a rising edge of `tx_fifo_empty_i` and holds until acknowledged through bit 2. If the FIFO is still empty, the acknowledge clears the bit for one cycle and the bit then sets again.
- R6: Status bit 5 (port event) sets after any of `link_evt_i`, `ctr_roll_evt_i` or `tx_fatal_evt_i`, and holds until acknowledged through bit 5.
- R7: `port_ovr_o` sets the cycle after `rx_ovr_evt_i`. It clears the cycle after `rx_pkt_arrive_i` when no overrun comes at the same time.
- R8: A write of the acknowledge register (address 1) with bit 0 at 1 while `tx_cmp_empty_i` is low drives `tx_pop_o` high for exactly the next cycle. If the FIFO is empty, no pop is issued.
- R9: Acknowledge bits written as 0, and acknowledge bits at the live positions 1 and 3, leave the status word unchanged.
- R10: When a latching event and its acknowledge occur in the same cycle, the bit is set afterwards.
- R11: `irq_o` is the OR of the status word ANDed bitwise with the mask register. The mask is loaded by a write to address 2.
- R12: Synchronous reset clears the sticky bits, the mask and the port overrun flag. `reg_rdata_o` shows, one cycle after the address, the status (address 0) or the mask (address 2). It shows 0 for addresses 1 and 3. Status bits 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_cmp_empty_i | input | 1 | Transmit-completion FIFO empty |
| rx_pkt_empty_i | input | 1 | Receive packet-number FIFO empty |
| alloc_failed_i | input | 1 | Allocation result failed flag |
| tx_fifo_empty_i | input | 1 | Transmit queue empty level |
| rx_ovr_evt_i | input | 1 | Receive overrun event pulse |
| rx_pkt_arrive_i | input | 1 | New packet received pulse |
| link_evt_i | input | 1 | Link test transition pulse |
| ctr_roll_evt_i | input | 1 | Statistics counter rollover pulse |
| tx_fatal_evt_i | input | 1 | Fatal transmit error pulse |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request |
| tx_pop_o | output | 1 | Pop strobe to transmit-completion FIFO |
| port_ovr_o | output | 1 | Port status overrun flag |

## Verification
The live bits and `irq_o` respond in the same cycle as the inputs. The bench therefore checks `irq_o` one time unit after it drives the inputs, before the next edge. Sticky bits, the mask, `tx_pop_o`, `port_ovr_o` and `reg_rdata_o` all change at the first rising edge after their cause. The bench samples them a quarter period after that edge. It compares them with a model that steps once per edge. A readback shows the status as it was before that edge, so a sticky bit shows in `reg_rdata_o` one step after it shows in `irq_o`. The clear-then-read sequence of R5 is therefore checked over three successive steps.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int STAT_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int N_LATCH = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 2'd0,
    A_ACK  = 2'd1,
    A_MASK = 2'd2
  } addr_e;

  localparam int B_TXDONE  = 0;
  localparam int B_RXPKT   = 1;
  localparam int B_TXEMPTY = 2;
  localparam int B_ALLOC   = 3;
  localparam int B_RXOVR   = 4;
  localparam int B_PORTEV  = 5;
endpackage

// File: rtl/nic_irq_latch.sv
module nic_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic lvl_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= set_i | (~clr_i & (q_o | lvl_i));
  end

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst) set_i |=> q_o); // R10
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst) (q_o && !clr_i) |=> q_o); // R4
endmodule

// File: rtl/nic_irq_regs.sv
module nic_irq_regs
  import nic_irq_pkg::*;
#(
  parameter int W  = STAT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  stat_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  ack_o
);
  logic wr_mask;
  assign wr_mask = wr_i && (addr_i == A_MASK);
  assign ack_o   = (wr_i && (addr_i == A_ACK)) ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) mask_o <= '0;
    else if (wr_mask) mask_o <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else begin
      case (addr_i)
        A_STAT:  rdata_o <= stat_i;
        A_MASK:  rdata_o <= mask_o;
        default: rdata_o <= '0;
      endcase
    end
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst) wr_mask |=> (mask_o == $past(wdata_i))); // R11
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
#(
  parameter int W  = STAT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_cmp_empty_i,
  input  logic          rx_pkt_empty_i,
  input  logic          alloc_failed_i,
  input  logic          tx_fifo_empty_i,
  input  logic          rx_ovr_evt_i,
  input  logic          rx_pkt_arrive_i,
  input  logic          link_evt_i,
  input  logic          ctr_roll_evt_i,
  input  logic          tx_fatal_evt_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic [W-1:0]  reg_wdata_i,
  output logic [W-1:0]  reg_rdata_o,
  output logic          irq_o,
  output logic          tx_pop_o,
  output logic          port_ovr_o
);
  localparam int LPOS [N_LATCH] = '{B_TXEMPTY, B_RXOVR, B_PORTEV};

  logic [W-1:0]       stat, mask, ack;
  logic [N_LATCH-1:0] set_v, lvl_v, q_v;
  logic               txe_prev;

  always_ff @(posedge clk) begin
    if (rst) txe_prev <= 1'b0;
    else     txe_prev <= tx_fifo_empty_i;
  end

  assign set_v[0] = tx_fifo_empty_i & ~txe_prev;
  assign set_v[1] = rx_ovr_evt_i;
  assign set_v[2] = link_evt_i | ctr_roll_evt_i | tx_fatal_evt_i;
  assign lvl_v    = {2'b00, tx_fifo_empty_i};

  generate
    for (genvar i = 0; i < N_LATCH; i++) begin : g_latch
      nic_irq_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_v[i]),
        .lvl_i (lvl_v[i]),
        .clr_i (ack[LPOS[i]]),
        .q_o   (q_v[i])
      );
    end
  endgenerate

  always_comb begin
    stat             = '0;
    stat[B_TXDONE]   = ~tx_cmp_empty_i;
    stat[B_RXPKT]    = ~rx_pkt_empty_i;
    stat[B_ALLOC]    = ~alloc_failed_i;
    for (int i = 0; i < N_LATCH; i++) stat[LPOS[i]] = q_v[i];
  end

  nic_irq_regs #(.W(W), .AW(AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (reg_addr_i),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .stat_i  (stat),
    .rdata_o (reg_rdata_o),
    .mask_o  (mask),
    .ack_o   (ack)
  );

  assign irq_o = |(stat & mask);

  always_ff @(posedge clk) begin
    if (rst) tx_pop_o <= 1'b0;
    else     tx_pop_o <= ack[B_TXDONE] & ~tx_cmp_empty_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                  port_ovr_o <= 1'b0;
    else if (rx_ovr_evt_i)    port_ovr_o <= 1'b1;
    else if (rx_pkt_arrive_i) port_ovr_o <= 1'b0;
  end

  AST_POP_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst) tx_pop_o |-> $past(ack[B_TXDONE] && !tx_cmp_empty_i)); // R8
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst) (ack[B_TXDONE] && tx_cmp_empty_i) |=> !tx_pop_o); // R8
  AST_TXE_REARM: assert property (@(posedge clk) disable iff (rst) (!stat[B_TXEMPTY] && tx_fifo_empty_i && !ack[B_TXEMPTY]) |=> stat[B_TXEMPTY]); // R5
  AST_POVR_CLEAR: assert property (@(posedge clk) disable iff (rst) (rx_pkt_arrive_i && !rx_ovr_evt_i) |=> !port_ovr_o); // R7
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (rst) rx_ovr_evt_i |=> (port_ovr_o && stat[B_RXOVR])); // R4
endmodule

// File: tb/nic_irq_status_tb.sv
module nic_irq_status_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic txc, rxe, af, txf, ovr, arr, lk, cr, ft, wr, irq, pop, povr;
  logic [1:0] addr;
  logic [7:0] wd, rd;

  nic_irq_status u_dut (
    .clk(clk), .rst(rst), .tx_cmp_empty_i(txc), .rx_pkt_empty_i(rxe),
    .alloc_failed_i(af), .tx_fifo_empty_i(txf), .rx_ovr_evt_i(ovr),
    .rx_pkt_arrive_i(arr), .link_evt_i(lk), .ctr_roll_evt_i(cr),
    .tx_fatal_evt_i(ft), .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .irq_o(irq), .tx_pop_o(pop), .port_ovr_o(povr)
  );

  int n_cmp = 0, n_bad = 0;
  logic m_txe = 0, m_ovr = 0, m_pev = 0, m_prev = 0, m_povr = 0;
  logic [7:0] m_mask = 0;

  function automatic logic [7:0] f_stat(logic c, logic r, logic a);
    return {2'b00, m_pev, m_ovr, ~a, m_txe, ~r, ~c};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, logic c, logic r, logic a, logic tf, logic o, logic ar,
                      logic l, logic ro, logic f, logic [1:0] ad, logic w, logic [7:0] d);
    logic [7:0] es, erd, ack;
    logic       epop;
    @(negedge clk);
    txc = c; rxe = r; af = a; txf = tf; ovr = o; arr = ar; lk = l; cr = ro; ft = f;
    addr = ad; wr = w; wd = d;
    #1;
    es = f_stat(c, r, a);
    chk("R11 irq", {7'd0, irq}, {7'd0, |(es & m_mask)});
    erd  = (ad == 2'd0) ? es : (ad == 2'd2) ? m_mask : 8'd0;
    ack  = (w && ad == 2'd1) ? d : 8'd0;
    epop = ack[0] & ~c;
    @(posedge clk);
    m_txe  = (tf & ~m_prev) | (~ack[2] & (m_txe | tf));
    m_prev = tf;
    m_ovr  = o | (m_ovr & ~ack[4]);
    m_pev  = (l | ro | f) | (m_pev & ~ack[5]);
    m_povr = o ? 1'b1 : (ar ? 1'b0 : m_povr);
    if (w && ad == 2'd2) m_mask = d;
    #5;
    chk(tag, rd, erd);
    chk("R8 pop", {7'd0, pop}, {7'd0, epop});
    chk("R7 port_ovr", {7'd0, povr}, {7'd0, m_povr});
  endtask

  task automatic idle(string tag, logic [1:0] ad);
    step(tag, 1, 1, 1, 0, 0, 0, 0, 0, 0, ad, 0, 8'd0);
  endtask

  task automatic wr_reg(string tag, logic [1:0] ad, logic [7:0] d);
    step(tag, 1, 1, 1, 0, 0, 0, 0, 0, 0, ad, 1, d);
  endtask

  logic done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    txc = 1; rxe = 1; af = 1; txf = 0; ovr = 0; arr = 0; lk = 0; cr = 0; ft = 0;
    addr = 0; wr = 0; wd = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    #1;
    chk("R12 reset irq", {7'd0, irq}, 8'd0);
    chk("R12 reset pop", {7'd0, pop}, 8'd0);
    idle("R12 reset mask", 2'd2);
    idle("R12 reset status", 2'd0);
    wr_reg("R12 mask write", 2'd2, 8'hFF);
    idle("R12 mask read", 2'd2);
    idle("R12 unused addr", 2'd3);
    // live bits
    step("R1", 0, 1, 1, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0);
    step("R2", 1, 0, 1, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0);
    step("R3", 1, 1, 0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0);
    // R4 overrun latch survives packet arrival
    step("R4", 1, 1, 1, 0, 1, 0, 0, 0, 0, 2'd0, 0, 0);
    step("R4", 1, 1, 1, 0, 0, 1, 0, 0, 0, 2'd0, 0, 0);
    idle("R4", 2'd0);
    wr_reg("R4", 2'd1, 8'h10);
    idle("R4", 2'd0);
    // R9: zeros and live positions do nothing
    step("R9", 1, 1, 1, 0, 1, 0, 0, 0, 0, 2'd0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd1, 1, 8'h0A);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0);
    idle("R9", 2'd0);
    // R10 event wins over simultaneous ack
    step("R10", 1, 1, 1, 0, 1, 0, 0, 0, 0, 2'd1, 1, 8'h10);
    idle("R10", 2'd0);
    wr_reg("R10", 2'd1, 8'h10);
    // R5 clear-then-read
    step("R5", 1, 1, 1, 1, 0, 0, 0, 0, 0, 2'd0, 0, 0);
    step("R5", 1, 1, 1, 1, 0, 0, 0, 0, 0, 2'd0, 0, 0);
    step("R5", 1, 1, 1, 1, 0, 0, 0, 0, 0, 2'd1, 1, 8'h04);
    step("R5", 1, 1, 1, 1, 0, 0, 0, 0, 0, 2'd0, 0, 0);
    step("R5", 1, 1, 1, 1, 0, 0, 0, 0, 0, 2'd0, 0, 0);
    step("R5", 1, 1, 1, 0, 0, 0, 0, 0, 0, 2'd1, 1, 8'h04);
    idle("R5", 2'd0);
    // R6 each cause
    step("R6", 1, 1, 1, 0, 0, 0, 1, 0, 0, 2'd0, 0, 0);
    wr_reg("R6", 2'd1, 8'h20);
    step("R6", 1, 1, 1, 0, 0, 0, 0, 1, 0, 2'd0, 0, 0);
    wr_reg("R6", 2'd1, 8'h20);
    step("R6", 1, 1, 1, 0, 0, 0, 0, 0, 1, 2'd0, 0, 0);
    idle("R6", 2'd0);
    wr_reg("R6", 2'd1, 8'h20);
    // R8 pop only when not empty
    step("R8", 0, 1, 1, 0, 0, 0, 0, 0, 0, 2'd1, 1, 8'h01);
    step("R8", 1, 1, 1, 0, 0, 0, 0, 0, 0, 2'd1, 1, 8'h01);
    idle("R8", 2'd0);
    // R11 single-bit masks
    wr_reg("R11", 2'd2, 8'h02);
    step("R11", 1, 0, 1, 0, 0, 0, 0, 0, 0, 2'd2, 0, 0);
    step("R11", 0, 1, 0, 0, 0, 0, 0, 0, 0, 2'd2, 0, 0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] ad;
      logic w;
      ad = 2'($urandom_range(0, 3));
      w  = ($urandom_range(0, 3) == 0);
      step("R12 random", 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 5) == 0), ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0),
           ad, w, 8'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule